// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for a synchronous burst memory array. On a clock edge where a load is accepted, it captures a complete external address. On later edges it walks through the aligned group of four words that holds that address. Only the two lowest address bits move during a burst. The upper bits keep the captured value until the next load.

There are two active-low load strobes. The controller-side strobe always loads. The processor-side strobe loads only while an active-low gating input is low. An active-low step input moves the burst one position forward, and a step input held high suspends the burst. A static order-select input chooses the walk. With order select low the walk is a wrap-around increment. With order select high it is an interleaved walk, in which each position is the start value XOR-ed with a position count. Alongside the address, two single-cycle flags report whether the last edge loaded or advanced.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and on the first output after reset, `cur_addr` is 0 and both `load_evt` and `adv_evt` are 0.
- R2: When `ctrl_stb_n` is sampled low on a rising edge, `cur_addr` equals the sampled `ext_addr` after that edge, `load_evt` is 1 and `adv_evt` is 0.
- R3: The same sampled low `proc_stb_n` gives a load when `proc_gate_n` is sampled low. It has no effect when `proc_gate_n` is high. In that case the edge acts as if no strobe were asserted: it holds the address, or advances it if `step_n` is low.
- R4: With `order_xor` = 0, the k-th advance after a load with low bits s gives low bits (s + k) mod 4.
- R5: With `order_xor` = 1, the k-th advance after a load with low bits s gives low bits s XOR (k mod 4).
- R6: The walk wraps. The fourth advance after a load returns the low bits to the loaded start value, and further advances repeat the same four addresses.
- R7: An edge with no accepted load and `step_n` high leaves `cur_addr` unchanged, and both flags are 0 afterwards.
- R8: When a load is accepted and `step_n` is low on the same edge, the load wins: `cur_addr` takes `ext_addr`, `load_evt` is 1 and `adv_evt` is 0.
- R9: Address bits above the lowest two change only on a load edge.
- R10: A load in the middle of a burst restarts the walk. The next advance is the first step from the newly loaded low bits.
- R11: After each accepted advance edge, `adv_evt` is 1 and `load_evt` is 0 for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_stb_n | input | 1 | Processor-side load strobe, active low, gated by `proc_gate_n` |
| ctrl_stb_n | input | 1 | Controller-side load strobe, active low, never gated |
| proc_gate_n | input | 1 | Active-low enable; when high, blocks `proc_stb_n` |
| step_n | input | 1 | Active-low burst advance |
| order_xor | input | 1 | Static order select: 0 wrap-around increment, 1 interleaved |
| ext_addr | input | ADDR_W | External word address captured on a load |
| cur_addr | output | ADDR_W | Current array word address |
| load_evt | output | 1 | The last edge accepted a load |
| adv_evt | output | 1 | The last edge advanced the burst |

## Verification
A load and an advance can both be requested on the same edge. Two cases show this: a strobe and `step_n` low together, and a processor strobe that is blocked while `step_n` is low. The bench drives both cases in the middle of bursts. It judges them against a behavioural model that resolves the load first and applies the step only when no load was accepted. The address and both flags are compared after every edge, so a wrong winner or a counter that was not restarted shows up on the next advance.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic load;
    logic adv;
  } seq_evt_t;

endpackage

// File: rtl/strobe_arbiter.sv
module strobe_arbiter
  import burst_seq_pkg::*;
(
  input  logic     proc_stb_n,
  input  logic     ctrl_stb_n,
  input  logic     proc_gate_n,
  input  logic     step_n,
  output seq_evt_t take
);

  logic proc_ok;
  logic ctrl_ok;

  assign proc_ok = ~proc_stb_n & ~proc_gate_n;
  assign ctrl_ok = ~ctrl_stb_n;

  always_comb begin
    take.load = proc_ok | ctrl_ok;
    take.adv  = ~(proc_ok | ctrl_ok) & ~step_n;
  end

endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
  import burst_seq_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take_load,
  input  logic                  take_adv,
  input  logic [BURST_BITS-1:0] start_in,
  input  burst_order_e          order,
  output logic [BURST_BITS-1:0] low_out
);

  localparam int                  BB     = BURST_BITS;
  localparam logic [BB-1:0]       K_LAST = {BB{1'b1}};

  logic [BB-1:0] start_q;
  logic [BB-1:0] k_q;
  logic [BB-1:0] low_wrap;
  logic [BB-1:0] low_xor;

  function automatic logic [BB-1:0] wrap_pos(input logic [BB-1:0] s, input logic [BB-1:0] k);
    return BB'(s + k);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      k_q     <= '0;
    end else if (take_load) begin
      start_q <= start_in;
      k_q     <= '0;
    end else if (take_adv) begin
      k_q     <= BB'(k_q + 1'b1);
    end
  end

  assign low_wrap = wrap_pos(start_q, k_q);

  for (genvar b = 0; b < BB; b++) begin : g_xor_bit
    assign low_xor[b] = start_q[b] ^ k_q[b];
  end

  assign low_out = (order == ORD_XOR) ? low_xor : low_wrap;

  p_adv_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_adv |=> k_q == BB'($past(k_q) + 1'b1));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_adv && k_q == K_LAST) |=> (k_q == '0 && low_out == start_q));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_load |=> (k_q == '0 && start_q == $past(start_in)));

endmodule

// File: rtl/upper_addr_hold.sv
module upper_addr_hold #(
  parameter int UP_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_load,
  input  logic [UP_W-1:0] up_in,
  output logic [UP_W-1:0] up_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) up_q <= '0;
    else if (take_load) up_q <= up_in;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              proc_gate_n,
  input  logic              step_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              load_evt,
  output logic              adv_evt
);

  localparam int UP_W = ADDR_W - BURST_BITS;

  seq_evt_t              take;
  seq_evt_t              evt_q;
  logic [BURST_BITS-1:0] low_now;
  logic [UP_W-1:0]       up_now;
  burst_order_e          order;

  assign order = burst_order_e'(order_xor);

  strobe_arbiter u_arb (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .proc_gate_n(proc_gate_n),
    .step_n     (step_n),
    .take       (take)
  );

  burst_step_ctr #(.BURST_BITS(BURST_BITS)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_load(take.load),
    .take_adv (take.adv),
    .start_in (ext_addr[BURST_BITS-1:0]),
    .order    (order),
    .low_out  (low_now)
  );

  upper_addr_hold #(.UP_W(UP_W)) u_up (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_load(take.load),
    .up_in    (ext_addr[ADDR_W-1:BURST_BITS]),
    .up_q     (up_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= take;
  end

  assign cur_addr = {up_now, low_now};
  assign load_evt = evt_q.load;
  assign adv_evt  = evt_q.adv;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_stb_n |=> (cur_addr == $past(ext_addr) && load_evt));

  p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_gate_n && ctrl_stb_n) |=> !load_evt);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_gate_n && ctrl_stb_n && step_n) |=> ($stable(cur_addr) && !load_evt && !adv_evt));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_stb_n && !step_n) |=> (load_evt && !adv_evt));

  p_upper_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |-> $stable(cur_addr[ADDR_W-1:BURST_BITS]));

  p_evt_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_evt, adv_evt}));

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int CLK_NS = 10;
  localparam int AW     = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          proc_stb_n, ctrl_stb_n, proc_gate_n, step_n, order_xor;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] cur_addr;
  logic          load_evt, adv_evt;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_addr, m_start, m_k;
  bit m_ld, m_av;

  burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .proc_gate_n(proc_gate_n), .step_n(step_n), .order_xor(order_xor),
    .ext_addr(ext_addr), .cur_addr(cur_addr), .load_evt(load_evt), .adv_evt(adv_evt)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic compare(input string tag);
    n_cmp++;
    if (cur_addr !== AW'(m_addr) || load_evt !== m_ld || adv_evt !== m_av) begin
      n_bad++;
      $display("FAIL %s: addr=%h exp %h load=%b exp %b adv=%b exp %b",
               tag, cur_addr, AW'(m_addr), load_evt, m_ld, adv_evt, m_av);
    end
  endtask

  // drives inputs at a falling edge, models the next rising edge, compares at the next falling edge
  task automatic cyc(input bit ps, input bit cs, input bit gate, input bit st,
                     input int a, input string tag);
    bit ld;
    proc_stb_n = ps; ctrl_stb_n = cs; proc_gate_n = gate; step_n = st;
    ext_addr = AW'(a);
    @(posedge clk);
    ld = (cs == 1'b0) || (ps == 1'b0 && gate == 1'b0);
    m_ld = 0; m_av = 0;
    if (ld) begin
      m_addr = a & ((1 << AW) - 1);
      m_start = a % 4;
      m_k = 0;
      m_ld = 1;
    end else if (st == 1'b0) begin
      m_k = (m_k + 1) % 4;
      if (order_xor) m_addr = (m_addr / 4) * 4 + (m_start ^ m_k);
      else           m_addr = (m_addr / 4) * 4 + ((m_start + m_k) % 4);
      m_av = 1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input bit ilv);
    order_xor = ilv;
    rst_n = 1'b0;
    proc_stb_n = 1; ctrl_stb_n = 1; proc_gate_n = 1; step_n = 1; ext_addr = '1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_addr = 0; m_start = 0; m_k = 0; m_ld = 0; m_av = 0;
    compare("R1 during reset");
    rst_n = 1'b1;
    cyc(1, 1, 1, 1, 'h1F0F3, "R1 first cycle after reset");
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // wrap-around order
    do_reset(1'b0);
    cyc(1, 0, 1, 1, 'h12345, "R2 ctrl load");
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, 'h00000, "R4 R6 R9 wrap advance");
    cyc(1, 1, 1, 1, 'h0FFFF, "R7 suspend");
    cyc(1, 1, 0, 1, 'h0FFFF, "R7 suspend gate low");
    cyc(0, 1, 0, 1, 'h0ABCE, "R3 proc load gate low");
    cyc(1, 1, 1, 0, 'h00000, "R4 advance");
    cyc(0, 1, 1, 1, 'h15555, "R3 blocked proc hold");
    cyc(0, 1, 1, 0, 'h15555, "R3 blocked proc advances");
    cyc(1, 0, 1, 0, 'h1FFFF, "R8 ctrl load beats step");
    cyc(1, 1, 1, 0, 'h00000, "R10 R11 first step after reload");
    cyc(0, 1, 0, 0, 'h00002, "R8 R10 proc load mid burst");
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 'h1AAAA, "R4 R6 R11 walk from 10");
    cyc(0, 0, 1, 1, 'h0C3C1, "R2 both strobes");
    cyc(1, 1, 1, 0, 'h00000, "R4 advance from 01");
    // interleaved order
    do_reset(1'b1);
    for (int s = 0; s < 4; s++) begin
      cyc(1, 0, 1, 1, 'h0A5A4 + s, "R2 ctrl load xor");
      for (int i = 0; i < 5; i++) begin
        cyc(1, 1, 1, 0, 'h00000, "R5 R6 R9 xor advance");
        if (i == 1) cyc(1, 1, 1, 1, 'h1FFFF, "R7 xor suspend");
      end
    end
    cyc(0, 1, 0, 1, 'h13337, "R3 proc load xor");
    cyc(1, 1, 1, 0, 'h00000, "R5 step");
    cyc(0, 1, 1, 0, 'h00000, "R3 blocked proc advances xor");
    cyc(1, 0, 1, 0, 'h00001, "R8 R10 reload beats step xor");
    cyc(1, 1, 1, 0, 'h00000, "R5 R10 R11 first step after reload");
    cyc(1, 1, 1, 0, 'h00000, "R5 second step after reload");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule